// File: doc/BRIEF.md
# Outer-Product Int8 Multiply-Accumulate Unit

This block is a pipelined compute unit placed next to a memory array. Input bytes are streamed in one at a time and held in a small input buffer. Each weight beat from the array carries 64 signed 8-bit weights. The oldest buffered input byte is multiplied against all 64 weights, and each product is added into its own 16-bit saturating accumulator. Every beat is therefore a rank-one (outer-product) update of 64 partial sums. There is no reduction tree.

The input stream and the weight bus are valid/ready channels. A transfer happens on a rising edge where valid and ready are both high, and a sender must hold its data while valid is high and ready is low. The input buffer raises back-pressure when it is full. The weight bus raises back-pressure when no input byte is buffered.

The partial sums leave through a valid/ready readout channel that carries four accumulators per beat. The clear input and the readout start input are plain one-cycle controls. While a readout is in progress, both inbound channels are stalled.

Top module: `opmac_unit`

## Requirements
- R1: After reset, in_ready is 1, w_ready is 0 and out_valid is 0, and all 64 accumulators read as zero.
- R2: The input buffer holds up to 64 bytes in arrival order. A byte is accepted on an edge with in_valid and in_ready high, and in_ready is 0 while 64 bytes are held.
- R3: w_ready is 1 exactly when at least one input byte is buffered and no readout is in progress. Each accepted weight beat consumes the oldest buffered byte.
- R4: An accepted beat adds the signed product x*w[j] to accumulator j for every j from 0 to 63. x is the consumed byte and w[j] is w_data[8j+7:8j], both two's complement.
- R5: The unit accepts one weight beat per cycle back to back with none lost. Accumulator state trails an accepted beat by two cycles: one multiply stage, then one accumulate stage.
- R6: Each accumulator saturates to the range -32768..32767 instead of wrapping. A later beat may move a saturated value back inside the range.
- R7: acc_clear high in a cycle with no accepted beat sets every accumulator to zero.
- R8: acc_clear high in the same cycle as an accepted beat loads each accumulator with that beat's product, discarding the old sum.
- R9: A pulse on rd_start starts a readout of 16 beats. Beat i carries accumulators 4i..4i+3, with accumulator 4i in out_data[15:0]. out_last is 1 on beat 15. out_valid and out_data hold while out_ready is 0. The first beat waits until the pipeline has settled.
- R10: During a readout, in_ready and w_ready are 0, and rd_start and acc_clear are ignored. A readout leaves the accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input buffer can accept a byte |
| in_data | input | 8 | Signed input byte |
| w_valid | input | 1 | Weight beat valid |
| w_ready | output | 1 | Weight beat can be accepted |
| w_data | input | 512 | 64 signed weight bytes, weight j in bits 8j+7:8j |
| acc_clear | input | 1 | Clear the accumulators, aligned with the beat of the same cycle |
| rd_start | input | 1 | Start a readout of all accumulators |
| out_valid | output | 1 | Readout beat valid |
| out_ready | input | 1 | Receiver takes the readout beat |
| out_data | output | 64 | Four 16-bit signed accumulators |
| out_last | output | 1 | Final beat of a readout |

## Verification
The bench builds the unit with its default parameters: 64 lanes, a 64-entry input buffer and four accumulators per readout beat. With these values the buffer can be filled to full back-pressure and then emptied by 64 back-to-back weight beats, and every lane position in the readout order is observed. Three beats of extreme products drive lanes past both saturation limits, and a further beat shows that a saturated value can move back. Clear is exercised both alone and together with a beat. During a readout the bench applies stalls on out_ready and pokes every inbound control.

// File: rtl/opmac_pkg.sv
package opmac_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    DRAIN_IDLE = 1'b0,
    DRAIN_BUSY = 1'b1
  } drain_st_t;
endpackage

// File: rtl/opmac_inbuf.sv
module opmac_inbuf #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0)); // R3
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(DEPTH))); // R2
endmodule

// File: rtl/opmac_lane.sv
module opmac_lane #(
  parameter int BW = 8,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BW-1:0]        x,
  input  logic [BW-1:0]        w,
  input  logic                 fire,
  input  logic                 v1,
  input  logic                 c1,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * BW;
  localparam logic signed [AW-1:0] SMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [PW-1:0] prod_q;
  logic signed [AW-1:0] acc_q;
  logic signed [AW:0]   a_ext, p_ext, sum;
  logic signed [AW-1:0] p_load, sat_val;

  // Multiply stage
  always_ff @(posedge clk) begin
    if (!rst_n)    prod_q <= '0;
    else if (fire) prod_q <= $signed(x) * $signed(w);
  end

  // Accumulate stage
  always_comb begin
    a_ext  = acc_q;
    p_ext  = prod_q;
    p_load = prod_q;
    sum    = a_ext + p_ext;
    if (sum[AW] != sum[AW-1]) sat_val = sum[AW] ? SMIN : SMAX;
    else                      sat_val = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (v1 && c1)   acc_q <= p_load;
    else if (v1)         acc_q <= sat_val;
    else if (c1)         acc_q <= '0;
  end

  assign acc = acc_q;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !c1 && acc_q == SMAX && prod_q >= 0) |=> (acc_q == SMAX)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (c1 && !v1) |=> (acc_q == '0)); // R7
endmodule

// File: rtl/opmac_drain.sv
module opmac_drain
  import opmac_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int AW       = 16,
  parameter int PER_BEAT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      pipe_busy,
  input  logic [LANES*AW-1:0]       acc_flat,
  input  logic                      out_ready,
  output logic                      busy,
  output logic                      out_valid,
  output logic [PER_BEAT*AW-1:0]    out_data,
  output logic                      out_last
);
  localparam int BEATS  = LANES / PER_BEAT;
  localparam int IW     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BEAT_W = PER_BEAT * AW;

  drain_st_t     st_q;
  logic [IW-1:0] idx_q;
  logic          take;

  assign busy      = (st_q == DRAIN_BUSY);
  assign out_valid = busy && !pipe_busy;
  assign take      = out_valid && out_ready;
  assign out_last  = (idx_q == IW'(BEATS - 1));
  assign out_data  = acc_flat[int'(idx_q) * BEAT_W +: BEAT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= DRAIN_IDLE;
      idx_q <= '0;
    end else if (st_q == DRAIN_IDLE) begin
      if (start) st_q <= DRAIN_BUSY;
      idx_q <= '0;
    end else if (take) begin
      if (out_last) begin
        st_q  <= DRAIN_IDLE;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(idx_q))); // R9
endmodule

// File: rtl/opmac_unit.sv
module opmac_unit
  import opmac_pkg::*;
#(
  parameter int LANES    = 64,
  parameter int DEPTH    = 64,
  parameter int AW       = 16,
  parameter int PER_BEAT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BYTE_W-1:0]         in_data,
  input  logic                      w_valid,
  output logic                      w_ready,
  input  logic [LANES*BYTE_W-1:0]   w_data,
  input  logic                      acc_clear,
  input  logic                      rd_start,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [PER_BEAT*AW-1:0]    out_data,
  output logic                      out_last
);
  logic              draining, buf_empty, buf_full;
  logic              push, fire, clr0;
  logic              v1, c1;
  logic [BYTE_W-1:0] x_head;
  logic [LANES*AW-1:0] acc_flat;

  assign in_ready = !buf_full && !draining;
  assign w_ready  = !buf_empty && !draining;
  assign push     = in_valid && in_ready;
  assign fire     = w_valid && w_ready;
  assign clr0     = acc_clear && !draining;

  opmac_inbuf #(.DEPTH(DEPTH), .W(BYTE_W)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .pop       (fire),
    .head      (x_head),
    .empty     (buf_empty),
    .full      (buf_full)
  );

  // Beat valid and clear travel one stage alongside the products
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      c1 <= 1'b0;
    end else begin
      v1 <= fire;
      c1 <= clr0;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [AW-1:0] acc_j;
    opmac_lane #(.BW(BYTE_W), .AW(AW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (x_head),
      .w     (w_data[j*BYTE_W +: BYTE_W]),
      .fire  (fire),
      .v1    (v1),
      .c1    (c1),
      .acc   (acc_j)
    );
    assign acc_flat[j*AW +: AW] = acc_j;
  end

  opmac_drain #(.LANES(LANES), .AW(AW), .PER_BEAT(PER_BEAT)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_start),
    .pipe_busy (v1 || c1),
    .acc_flat  (acc_flat),
    .out_ready (out_ready),
    .busy      (draining),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: tb/opmac_unit_tb.sv
module opmac_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_data = '0;
  logic         w_valid = 1'b0;
  logic         w_ready;
  logic [511:0] w_data = '0;
  logic         acc_clear = 1'b0;
  logic         rd_start = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_data;
  logic         out_last;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_acc [64];
  logic [7:0] fifo_q [$];

  always #2 clk = ~clk;

  opmac_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .acc_clear(acc_clear), .rd_start(rd_start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // mode 0: mixed pattern; mode 1: extreme values by lane
  function automatic logic [7:0] wgen(input int mode, input int seed, input int j);
    if (mode == 1) begin
      case (j % 4)
        0: return 8'd127;
        1: return 8'h80;
        2: return 8'd1;
        default: return 8'd0;
      endcase
    end
    return 8'((seed * 37 + j * 11 + 5) & 255);
  endfunction

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    fifo_q.push_back(b);
  endtask

  task automatic send_beat(input int mode, input int seed, input bit clr);
    logic [7:0] x;
    @(negedge clk);
    for (int j = 0; j < 64; j++) w_data[8*j +: 8] = wgen(mode, seed, j);
    w_valid   = 1'b1;
    acc_clear = clr;
    while (!w_ready) @(negedge clk);
    @(posedge clk);
    #1 w_valid = 1'b0;
    acc_clear = 1'b0;
    x = fifo_q.pop_front();
    for (int j = 0; j < 64; j++) begin
      int p;
      p = int'($signed(x)) * int'($signed(wgen(mode, seed, j)));
      exp_acc[j] = clr ? p : sat16(exp_acc[j] + p);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    acc_clear = 1'b1;
    @(posedge clk);
    #1 acc_clear = 1'b0;
    for (int j = 0; j < 64; j++) exp_acc[j] = 0;
  endtask

  task automatic drain_check(input string req, input bit stall, input bit poke);
    @(negedge clk);
    rd_start = 1'b1;
    @(posedge clk);
    #1 rd_start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      int guard = 0;
      @(negedge clk);
      while (!out_valid && guard < 20) begin
        @(negedge clk);
        guard++;
      end
      check(out_valid, {req, " R9 beat valid"}, int'(out_valid), 1);
      for (int k = 0; k < 4; k++) begin
        int a;
        a = int'($signed(out_data[16*k +: 16]));
        check(a == exp_acc[4*i + k], req, a, exp_acc[4*i + k]);
      end
      check(out_last == (i == 15), "R9 out_last", int'(out_last), int'(i == 15));
      check(!in_ready && !w_ready, "R10 stalled during readout",
            int'({in_ready, w_ready}), 0);
      if (stall && i == 5) begin
        logic [63:0] held;
        held = out_data;
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid && out_data == held, "R9 hold under stall",
              int'(out_valid), 1);
        out_ready = 1'b1;
      end
      if (poke && i == 3) begin
        rd_start  = 1'b1;
        acc_clear = 1'b1;
        in_valid  = 1'b1;
        in_data   = 8'h55;
        w_valid   = 1'b1;
        @(posedge clk);
        #1;
        rd_start  = 1'b0;
        acc_clear = 1'b0;
        in_valid  = 1'b0;
        w_valid   = 1'b0;
        continue;
      end
      @(posedge clk);
    end
    @(negedge clk);
    check(!out_valid, "R9 readout ends after 16 beats", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(w_ready == 1'b0, "R1 w_ready", int'(w_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    drain_check("R1 zero accumulators", 1'b0, 1'b0);
  endtask

  task automatic t_fill_and_stream();
    for (int n = 0; n < 64; n++) push_byte(8'((n * 29 + 3) & 255));
    @(negedge clk);
    check(!in_ready, "R2 full buffer back-pressure", int'(in_ready), 0);
    check(w_ready, "R3 w_ready with bytes held", int'(w_ready), 1);
    for (int n = 0; n < 64; n++) send_beat(0, n, 1'b0);
    @(negedge clk);
    check(!w_ready, "R3 w_ready low when empty", int'(w_ready), 0);
    check(in_ready, "R2 in_ready after drain of buffer", int'(in_ready), 1);
    drain_check("R4 R5 outer-product sums", 1'b1, 1'b0);
  endtask

  task automatic t_clear();
    pulse_clear();
    drain_check("R7 clear alone", 1'b0, 1'b0);
    push_byte(8'd9);
    push_byte(8'hF3);
    send_beat(0, 100, 1'b0);
    send_beat(0, 101, 1'b1);
    drain_check("R8 clear with beat", 1'b0, 1'b0);
  endtask

  task automatic t_saturate();
    pulse_clear();
    push_byte(8'd127);
    push_byte(8'd127);
    push_byte(8'd127);
    push_byte(8'hFF);
    send_beat(1, 0, 1'b0);
    send_beat(1, 0, 1'b0);
    send_beat(1, 0, 1'b0);
    drain_check("R6 saturated both limits", 1'b0, 1'b0);
    send_beat(1, 0, 1'b0);
    drain_check("R6 recovery from saturation", 1'b0, 1'b0);
  endtask

  task automatic t_readout_rules();
    drain_check("R10 pokes ignored", 1'b1, 1'b1);
    check(!w_ready, "R10 byte not taken during readout", int'(w_ready), 0);
    drain_check("R10 readout non-destructive", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 64; j++) exp_acc[j] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_stream();
    t_clear();
    t_saturate();
    t_readout_rules();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule